// File: doc/BRIEF.md
# Hopping Phase Accumulator with Frequency and Quadrant Modulation

This block produces the phase ramp for a digital oscillator. A wide register advances by a frequency increment on every clock and wraps modulo 2^N. Its top P bits go on to a separate phase-to-amplitude stage. The output frequency is the increment times the clock rate divided by 2^N. For example, with N = 32 and a 100 MHz clock, an increment of 2^30 gives 25 MHz.

The increment is double-buffered. A host writes a new word into a staging register at any time, and a separate commit strobe moves it into the active register on the chosen edge, so the oscillator hops from one frequency to the next with no intermediate value. While running, a signed deviation sample is scaled by a power of two and added to the active word, which gives live FM. A two-bit selector adds a quarter-turn multiple to the phase after the accumulator, which gives QPSK-style phase modulation without disturbing the accumulated phase. The reset input is assumed to be already released synchronously to `clk`.

Top module: `nco_hop_acc`

## Requirements
- R1: On each rising edge with `rst_n` high and `phase_clr` low, the internal phase becomes (phase + increment) modulo 2^N.
- R2: A rising edge with `tw_wr` high captures `tw_word` into the staging register only. The frequency in use does not change until a commit.
- R3: A rising edge with `tw_upd` high copies the staging register into the active register, and the next edge accumulates with the new word. If `tw_wr` and `tw_upd` are both high on the same edge, the value staged before that edge is committed.
- R4: The increment is the active word plus `fm_dev` (two's complement, sign-extended) shifted left by DEV_SHIFT bits (default 8). The sum is formed in N+1 bits and wrapped modulo 2^N, so a negative deviation wraps correctly.
- R5: `ofs_sel` values 0, 1, 2 and 3 add 0, 2^(N-2), 2^(N-1) and 3·2^(N-2) to the phase before truncation. The offset never changes the accumulated phase.
- R6: `phase_clr` high on an edge sets the phase to zero and takes priority over accumulation. The active and staged words are left unchanged.
- R7: `rst_n` low clears the phase, both tuning words and `phase_out` to zero, asynchronously.
- R8: `phase_out` is bits [N-1:N-P] (default P = 12) of the offset phase, registered once. The value after edge k reflects the phase and `ofs_sel` just before edge k.
- R9: With N = 32, P = 12, an active word of 2^30 and zero deviation, `phase_out` starting from phase zero steps 0, 1024, 2048, 3072, 0 on successive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| tw_word | input | N | Tuning word to stage |
| tw_wr | input | 1 | Write `tw_word` into the staging register |
| tw_upd | input | 1 | Commit the staging register to the active register |
| fm_dev | input | DEV_W | Signed frequency deviation sample |
| ofs_sel | input | 2 | Quadrant phase offset select |
| phase_clr | input | 1 | Restart the phase at zero |
| phase_out | output | P | Truncated, offset phase |

## Verification
The bench targets the double-buffer ordering. A design that let a staged write leak straight into the increment would hop early. One that committed the freshly written word when write and commit coincide would skip a frequency. A negative deviation is driven from phase zero: a design that formed the sum without sign extension would jump forward instead of wrapping to the top of the circle. Offsets are applied and then removed to show that the underlying phase did not move, and a clear is issued mid-run to show that the word survives it and that the ramp restarts exactly at zero.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    QUAD_0   = 2'd0,
    QUAD_90  = 2'd1,
    QUAD_180 = 2'd2,
    QUAD_270 = 2'd3
  } quad_e;
endpackage

// File: rtl/nco_tw_buffer.sv
module nco_tw_buffer #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] tw_word,
  input  logic         tw_wr,
  input  logic         tw_upd,
  output logic [N-1:0] stg_q,
  output logic [N-1:0] act_q
);
  logic [N-1:0] stg_d, act_d;

  always_comb begin
    stg_d = stg_q;
    act_d = act_q;
    if (tw_upd) act_d = stg_q;
    if (tw_wr)  stg_d = tw_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      act_q <= '0;
    end else begin
      stg_q <= stg_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int N         = 32,
  parameter int DEV_W     = 16,
  parameter int DEV_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     act_word,
  input  logic [DEV_W-1:0] fm_dev,
  input  logic             phase_clr,
  output logic [N-1:0]     phase_q
);
  localparam int EXT_W = N + 1;

  logic [EXT_W-1:0] dev_ext;
  logic [EXT_W-1:0] inc_wide;
  logic [N-1:0]     inc;
  logic [N-1:0]     phase_d;

  always_comb begin
    dev_ext  = {{(EXT_W-DEV_W){fm_dev[DEV_W-1]}}, fm_dev} << DEV_SHIFT;
    inc_wide = {1'b0, act_word} + dev_ext;
    inc      = inc_wide[N-1:0];
    if (phase_clr) phase_d = '0;
    else           phase_d = phase_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out
  import nco_pkg::*;
#(
  parameter int N = 32,
  parameter int P = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] phase_q,
  input  quad_e        quad,
  output logic [P-1:0] phase_out
);
  localparam int LOW_W = N - 2;

  logic [N-1:0] offset;
  logic [N-1:0] shifted;
  logic [P-1:0] out_d;

  always_comb begin
    offset  = {quad, {LOW_W{1'b0}}};
    shifted = phase_q + offset;
    out_d   = shifted[N-1 -: P];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_out <= '0;
    else        phase_out <= out_d;
  end
endmodule

// File: rtl/nco_hop_acc.sv
module nco_hop_acc
  import nco_pkg::*;
#(
  parameter int N         = 32,
  parameter int P         = 12,
  parameter int DEV_W     = 16,
  parameter int DEV_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     tw_word,
  input  logic             tw_wr,
  input  logic             tw_upd,
  input  logic [DEV_W-1:0] fm_dev,
  input  logic [1:0]       ofs_sel,
  input  logic             phase_clr,
  output logic [P-1:0]     phase_out
);
  logic [N-1:0] stg_word;
  logic [N-1:0] act_word;
  logic [N-1:0] phase_q;
  quad_e        quad;

  assign quad = quad_e'(ofs_sel);

  nco_tw_buffer #(.N(N)) u_twbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .tw_word (tw_word),
    .tw_wr   (tw_wr),
    .tw_upd  (tw_upd),
    .stg_q   (stg_word),
    .act_q   (act_word)
  );

  nco_phase_acc #(.N(N), .DEV_W(DEV_W), .DEV_SHIFT(DEV_SHIFT)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_word  (act_word),
    .fm_dev    (fm_dev),
    .phase_clr (phase_clr),
    .phase_q   (phase_q)
  );

  nco_phase_out #(.N(N), .P(P)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_q   (phase_q),
    .quad      (quad),
    .phase_out (phase_out)
  );
endmodule

// File: rtl/nco_hop_acc_chk.sv
module nco_hop_acc_chk #(
  parameter int N     = 32,
  parameter int P     = 12,
  parameter int DEV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tw_wr,
  input logic             tw_upd,
  input logic             phase_clr,
  input logic [DEV_W-1:0] fm_dev,
  input logic [N-1:0]     stg_word,
  input logic [N-1:0]     act_word,
  input logic [N-1:0]     phase_q,
  input logic [P-1:0]     phase_out
);
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_clr && fm_dev == '0) |=> (phase_q - $past(phase_q)) == $past(act_word)); // R1

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tw_wr |=> $stable(stg_word)); // R2

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tw_upd |=> $stable(act_word)); // R3

  AST_COMMIT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    tw_upd |=> act_word == $past(stg_word)); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> phase_q == '0); // R6

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (phase_q == '0 && act_word == '0 && phase_out == '0)); // R7
endmodule

bind nco_hop_acc nco_hop_acc_chk #(.N(N), .P(P), .DEV_W(DEV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tw_wr     (tw_wr),
  .tw_upd    (tw_upd),
  .phase_clr (phase_clr),
  .fm_dev    (fm_dev),
  .stg_word  (stg_word),
  .act_word  (act_word),
  .phase_q   (phase_q),
  .phase_out (phase_out)
);

// File: tb/sim_nco_hop_acc.sv
`timescale 1ns/1ps
module sim_nco_hop_acc;
  localparam int N  = 32;
  localparam int P  = 12;
  localparam int DW = 16;
  localparam int DS = 8;
  localparam int NV = 16;
  localparam int VW = 3 + 2 + DW + N;

  // vector: {wr, upd, clr, ofs[1:0], dev[15:0], word[31:0]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b100, 2'd0, 16'h0000, 32'h0123_4567},
    {3'b010, 2'd0, 16'h0000, 32'h0000_0000},
    {3'b000, 2'd1, 16'h0000, 32'h0000_0000},
    {3'b000, 2'd3, 16'h0040, 32'h0000_0000},
    {3'b110, 2'd2, 16'hFF80, 32'h8000_0001},
    {3'b000, 2'd0, 16'h7FFF, 32'h0000_0000},
    {3'b010, 2'd1, 16'h8000, 32'h0000_0000},
    {3'b001, 2'd0, 16'h0000, 32'h0000_0000},
    {3'b000, 2'd2, 16'h1234, 32'h0000_0000},
    {3'b101, 2'd3, 16'h0000, 32'hFFFF_FFFF},
    {3'b010, 2'd0, 16'h0000, 32'h0000_0000},
    {3'b000, 2'd0, 16'h0001, 32'h0000_0000},
    {3'b000, 2'd1, 16'hFFFF, 32'h0000_0000},
    {3'b111, 2'd0, 16'h0000, 32'h4000_0000},
    {3'b000, 2'd2, 16'h0000, 32'h0000_0000},
    {3'b000, 2'd0, 16'h0000, 32'h0000_0000}
  };

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  tw_word;
  logic          tw_wr, tw_upd, phase_clr;
  logic [DW-1:0] fm_dev;
  logic [1:0]    ofs_sel;
  logic [P-1:0]  phase_out;

  int checks;
  int failures;

  logic [N-1:0] m_ph, m_act, m_stg;
  logic [P-1:0] m_out;

  nco_hop_acc #(.N(N), .P(P), .DEV_W(DW), .DEV_SHIFT(DS)) u0 (
    .clk (clk), .rst_n (rst_n), .tw_word (tw_word), .tw_wr (tw_wr),
    .tw_upd (tw_upd), .fm_dev (fm_dev), .ofs_sel (ofs_sel),
    .phase_clr (phase_clr), .phase_out (phase_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic [P-1:0] act, input logic [P-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at negedge: drive, model the edge, check at the following negedge
  task automatic step(input logic wr, input logic upd, input logic clr,
                      input logic [1:0] ofs, input logic [DW-1:0] dev,
                      input logic [N-1:0] word, input string tag);
    logic [N-1:0] dev32;
    tw_wr = wr; tw_upd = upd; phase_clr = clr; ofs_sel = ofs;
    fm_dev = dev; tw_word = word;
    @(posedge clk);
    dev32 = {{(N-DW){dev[DW-1]}}, dev} << DS;
    m_out = P'((m_ph + {ofs, {(N-2){1'b0}}}) >> (N-P));
    m_ph  = clr ? '0 : m_ph + m_act + dev32;
    if (upd) m_act = m_stg;
    if (wr)  m_stg = word;
    @(negedge clk);
    check(phase_out, m_out, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 2'd0, '0, '0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(phase_out, '0, "R7 async clear");
    m_ph = '0; m_act = '0; m_stg = '0; m_out = '0;
    tw_wr = 0; tw_upd = 0; phase_clr = 0; ofs_sel = 0; fm_dev = '0; tw_word = '0;
    repeat (2) @(negedge clk);
    check(phase_out, '0, "R7 held in reset");
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0;
    tw_wr = 0; tw_upd = 0; phase_clr = 0; ofs_sel = 0; fm_dev = '0; tw_word = '0;
    do_reset();

    // vector table walk against the requirement model (R1 R3 R4 R5 R6 R8)
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[VW-1], v[VW-2], v[VW-3], v[VW-4 -: 2], v[N+DW-1 -: DW], v[N-1:0], "R1 R8 vector");
    end
    repeat (4) idle("R1 vector tail");

    // R9 frequency hop to 2^30
    do_reset();
    step(1'b1, 1'b0, 1'b0, 2'd0, '0, 32'h4000_0000, "R2 stage");
    idle("R2 staged word not in use");
    check(phase_out, 12'd0, "R2 no hop before commit");
    idle("R2 still idle");
    check(phase_out, 12'd0, "R2 phase unchanged");
    step(1'b0, 1'b1, 1'b0, 2'd0, '0, '0, "R3 commit");
    idle("R9 first"); check(phase_out, 12'd0, "R9 step0");
    idle("R9 2");     check(phase_out, 12'd1024, "R9 step1");
    idle("R9 3");     check(phase_out, 12'd2048, "R9 step2");
    idle("R9 4");     check(phase_out, 12'd3072, "R9 step3");
    idle("R9 5");     check(phase_out, 12'd0, "R9 wrap");

    // R6 clear keeps the word
    step(1'b0, 1'b0, 1'b1, 2'd0, '0, '0, "R6 clear edge");
    idle("R6 a"); check(phase_out, 12'd0, "R6 restart at zero");
    idle("R6 b"); check(phase_out, 12'd1024, "R6 word kept");

    // R3 simultaneous write and commit
    do_reset();
    step(1'b1, 1'b0, 1'b0, 2'd0, '0, 32'h4000_0000, "R3 stage A");
    step(1'b1, 1'b1, 1'b0, 2'd0, '0, 32'h2000_0000, "R3 write B commit A");
    idle("R3 a"); check(phase_out, 12'd0, "R3 start");
    idle("R3 b"); check(phase_out, 12'd1024, "R3 old staged value committed");
    step(1'b0, 1'b1, 1'b0, 2'd0, '0, '0, "R3 commit B");
    idle("R3 c"); check(phase_out, 12'd3072, "R3 last step with A");
    idle("R3 d"); check(phase_out, 12'd3584, "R3 B in use");

    // R4 negative deviation wraps
    do_reset();
    step(1'b0, 1'b0, 1'b0, 2'd0, 16'hFFFF, '0, "R4 dev -1");
    idle("R4 a"); check(phase_out, 12'hFFF, "R4 negative wrap");

    // R5 offsets leave the phase alone
    do_reset();
    step(1'b0, 1'b0, 1'b0, 2'd1, '0, '0, "R5 q1"); check(phase_out, 12'd1024, "R5 quarter");
    step(1'b0, 1'b0, 1'b0, 2'd2, '0, '0, "R5 q2"); check(phase_out, 12'd2048, "R5 half");
    step(1'b0, 1'b0, 1'b0, 2'd3, '0, '0, "R5 q3"); check(phase_out, 12'd3072, "R5 three quarters");
    idle("R5 off"); check(phase_out, 12'd0, "R5 phase undisturbed");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule